// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block decides which hardware thread the retire stage of a multithreaded core serves next. Every thread presents a status code, a flag that says its oldest in-flight instruction is ready to retire, a flag that says its reorder buffer holds nothing, and the sequence number of that oldest instruction. The retire stage reads a thread index, or a "no thread" indication that ends retirement for the rest of the cycle. Because the grant is purely combinational, the retire stage can consult it again for every retire slot of a cycle as the inputs change.

A static policy input picks one of two arbitration styles. The first is a rotating priority order: the order is a list of thread indices, and the list changes only when the retire stage accepts a grant. The second picks the thread whose ready instruction is oldest, and this style also serves for the greedy policy. When the block is built for a single thread, arbitration is bypassed and only the status check remains.

Top module: `smt_commit_sel`

## Requirements
- R1: A thread can be granted only when its 3-bit status code is 0 (running), 1 (idle) or 4 (fetch trap pending). Codes 2 (squashing), 3 (trap pending), 5, 6 and 7 are never granted.
- R2: With `policyMode` = 0, the grant goes to the first thread in the priority list, scanned from the front, that has an allowed status and `headReady` set. The ROB-empty flag plays no part in this mode.
- R3: After reset the priority list holds the thread indices in ascending order, 0 at the front.
- R4: With `policyMode` = 0, an asserted `grantAccept` while a grant is valid takes the granted thread out of its place in the list and puts it at the back. The other threads keep their relative order. Without such an accept the list does not change.
- R5: With `policyMode` = 1, the grant goes to the thread with the smallest `headSeq` among the threads that have an allowed status, `headReady` set and `robEmpty` clear.
- R6: In mode 1, when two qualifying threads have equal sequence numbers, the lower thread index wins.
- R7: When no thread qualifies under the active policy, `grantValid` is 0 and `grantThread` is 0.
- R8: With `NUM_THREADS` = 1, thread 0 is granted whenever its status is allowed, whatever the values of `headReady`, `robEmpty` and `headSeq`.
- R9: In mode 1, `grantAccept` leaves the priority list untouched. The grant follows the inputs in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the priority list |
| rstN | input | 1 | Active-low synchronous reset |
| policyMode | input | 1 | 0 = rotating priority, 1 = oldest ready |
| grantAccept | input | 1 | The retire stage used the current grant |
| threadStatus | input | 3*NUM_THREADS | Status code per thread; thread t occupies bits [3t+2:3t] |
| headReady | input | NUM_THREADS | The head instruction of each thread is ready to retire |
| robEmpty | input | NUM_THREADS | The ROB of each thread is empty |
| headSeq | input | SEQ_W*NUM_THREADS | Head sequence number per thread, thread t at bits [SEQ_W*t +: SEQ_W] |
| grantValid | output | 1 | A thread is granted |
| grantThread | output | TID_W | Index of the granted thread (0 when none is granted) |

## Verification
`grantValid` and `grantThread` depend on the inputs and the stored list through logic alone. The bench therefore changes the inputs away from the rising edge and samples the grant one time step later, inside the same clock cycle. A change to the list appears only after the rising edge on which `grantAccept` was high. Each accept is therefore a pulse held across exactly one rising edge, and the list is checked afterwards through the next grant. Ignored inputs, such as an accept in oldest-ready mode, are checked by switching back to rotating priority and watching the grant that follows.

// File: rtl/smt_sel_pkg.sv
package smt_sel_pkg;

  typedef enum logic [2:0] {
    ST_RUNNING   = 3'd0,
    ST_IDLE      = 3'd1,
    ST_SQUASHING = 3'd2,
    ST_TRAPPEND  = 3'd3,
    ST_FETCHTRAP = 3'd4
  } thrStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useOldest;
    logic rotate;
  } selStrb_t;

  function automatic logic statusAllows(input logic [2:0] code);
    return (code == ST_RUNNING) || (code == ST_IDLE) || (code == ST_FETCHTRAP);
  endfunction

endpackage

// File: rtl/smt_sel_ctl.sv
module smt_sel_ctl
  import smt_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     policyMode,
  input  logic     grantAccept,
  output selStrb_t strb
);

  always_comb begin
    strb.useOldest = policyMode;
    strb.rotate    = grantAccept && !policyMode;
  end

  // R9
  oldest_no_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.useOldest |-> !strb.rotate);

endmodule

// File: rtl/smt_sel_dp.sv
module smt_sel_dp
  import smt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  selStrb_t                     strb,
  input  logic [3*NUM_THREADS-1:0]     threadStatus,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS-1:0]       robEmpty,
  input  logic [SEQ_W*NUM_THREADS-1:0] headSeq,
  output logic                         grantValid,
  output logic [TID_W-1:0]             grantThread
);

  localparam int NT = NUM_THREADS;

  logic [NT-1:0] statusOk;
  logic [NT-1:0] readyMask;

  for (genvar t = 0; t < NT; t++) begin : g_mask
    assign statusOk[t]  = statusAllows(threadStatus[3*t +: 3]);
    assign readyMask[t] = statusOk[t] && headReady[t];
  end

  if (NT == 1) begin : g_bypass
    // one thread: the status alone decides
    assign grantValid  = statusOk[0];
    assign grantThread = '0;
  end else begin : g_arb
    logic [NT-1:0][TID_W-1:0] prioList;
    logic                     rrHit;
    logic [TID_W-1:0]         rrPos;
    logic [TID_W-1:0]         rrTid;
    logic                     oldHit;
    logic [TID_W-1:0]         oldTid;
    logic [SEQ_W-1:0]         oldSeq;
    logic                     doRotate;

    // rotating priority: first ready thread from the front of the list
    always_comb begin
      rrHit = 1'b0;
      rrPos = '0;
      rrTid = '0;
      for (int p = 0; p < NT; p++) begin
        if (!rrHit && readyMask[prioList[p]]) begin
          rrHit = 1'b1;
          rrPos = TID_W'(p);
          rrTid = prioList[p];
        end
      end
    end

    // oldest ready: strict compare keeps the lower index on ties
    always_comb begin
      oldHit = 1'b0;
      oldTid = '0;
      oldSeq = '0;
      for (int t = 0; t < NT; t++) begin
        if (readyMask[t] && !robEmpty[t] &&
            (!oldHit || headSeq[SEQ_W*t +: SEQ_W] < oldSeq)) begin
          oldHit = 1'b1;
          oldTid = TID_W'(t);
          oldSeq = headSeq[SEQ_W*t +: SEQ_W];
        end
      end
    end

    assign grantValid  = strb.useOldest ? oldHit : rrHit;
    assign grantThread = strb.useOldest ? oldTid : rrTid;
    assign doRotate    = strb.rotate && rrHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int p = 0; p < NT; p++) prioList[p] <= TID_W'(p);
      end else if (doRotate) begin
        for (int p = 0; p < NT - 1; p++) begin
          if (TID_W'(p) >= rrPos) prioList[p] <= prioList[p+1];
        end
        prioList[NT-1] <= rrTid;
      end
    end

    // R4
    rotate_back_chk: assert property (@(posedge clk) disable iff (!rstN)
      doRotate |=> prioList[NT-1] == $past(rrTid));

    // R4
    list_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !doRotate |=> $stable(prioList));

    // R5
    oldest_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.useOldest && grantValid) |-> !robEmpty[grantThread]);

    // R7
    rr_no_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.useOldest && (|readyMask)) |-> grantValid);
  end

  // R1
  grant_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> statusAllows(threadStatus[3*grantThread +: 3]));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> grantThread == '0);

endmodule

// File: rtl/smt_commit_sel.sv
module smt_commit_sel
  import smt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         policyMode,
  input  logic                         grantAccept,
  input  logic [3*NUM_THREADS-1:0]     threadStatus,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS-1:0]       robEmpty,
  input  logic [SEQ_W*NUM_THREADS-1:0] headSeq,
  output logic                         grantValid,
  output logic [TID_W-1:0]             grantThread
);

  selStrb_t strb;

  smt_sel_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .policyMode  (policyMode),
    .grantAccept (grantAccept),
    .strb        (strb)
  );

  smt_sel_dp #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .threadStatus (threadStatus),
    .headReady    (headReady),
    .robEmpty     (robEmpty),
    .headSeq      (headSeq),
    .grantValid   (grantValid),
    .grantThread  (grantThread)
  );

  // R1
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && NUM_THREADS > 1) |-> headReady[grantThread]);

endmodule

// File: tb/smt_commit_sel_bench.sv
module smt_commit_sel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          policyMode = 1'b0;
  logic          grantAccept = 1'b0;
  logic [3*NT-1:0]  threadStatus = '0;
  logic [NT-1:0]    headReady = '0;
  logic [NT-1:0]    robEmpty = '0;
  logic [SW*NT-1:0] headSeq = '0;
  logic          grantValid;
  logic [1:0]    grantThread;

  logic [2:0]    sStatus = 3'd0;
  logic          sReady = 1'b0;
  logic          sEmpty = 1'b1;
  logic [SW-1:0] sSeq = '0;
  logic          sValid;
  logic          sThread;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_commit_sel #(.NUM_THREADS(NT), .SEQ_W(SW)) u_smt_commit_sel (
    .clk(clk), .rstN(rstN), .policyMode(policyMode), .grantAccept(grantAccept),
    .threadStatus(threadStatus), .headReady(headReady), .robEmpty(robEmpty),
    .headSeq(headSeq), .grantValid(grantValid), .grantThread(grantThread));

  smt_commit_sel #(.NUM_THREADS(1), .SEQ_W(SW)) u_smt_commit_sel_single (
    .clk(clk), .rstN(rstN), .policyMode(policyMode), .grantAccept(grantAccept),
    .threadStatus(sStatus), .headReady(sReady), .robEmpty(sEmpty),
    .headSeq(sSeq), .grantValid(sValid), .grantThread(sThread));

  task automatic expectGrant(input logic v, input int tid, input string req);
    #1;
    vecCount++;
    if (grantValid !== v || (grantThread !== 2'(tid))) begin
      errCount++;
      $display("FAIL %s: got valid=%0b thread=%0d, expected valid=%0b thread=%0d",
               req, grantValid, grantThread, v, tid);
    end
  endtask

  task automatic setStatus(input int t, input logic [2:0] code);
    threadStatus[3*t +: 3] = code;
  endtask

  task automatic setSeqs(input int a, input int b, input int c, input int d);
    headSeq = {SW'(d), SW'(c), SW'(b), SW'(a)};
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    grantAccept = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseAccept();
    @(negedge clk);
    grantAccept = 1'b1;
    @(posedge clk);
    #1 grantAccept = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    policyMode = 1'b0;
    threadStatus = {4{3'd2}};
    headReady = '1;
    expectGrant(1'b0, 0, "R7 all squashing");
    threadStatus = '0;
    expectGrant(1'b1, 0, "R3 initial list front");
  endtask

  task automatic testRoundRobin();
    doReset();
    policyMode = 1'b0;
    threadStatus = '0; headReady = '1; robEmpty = '1;
    expectGrant(1'b1, 0, "R2 ready ignores empty");
    pulseAccept(); // list 1 2 3 0
    expectGrant(1'b1, 1, "R4 rotate once");
    pulseAccept(); // list 2 3 0 1
    expectGrant(1'b1, 2, "R4 rotate twice");
    headReady[2] = 1'b0;
    expectGrant(1'b1, 3, "R2 skip unready");
    pulseAccept(); // list 2 0 1 3
    headReady = '1;
    expectGrant(1'b1, 2, "R4 middle removal keeps front");
    headReady = 4'b0010;
    expectGrant(1'b1, 1, "R2 only thread1 ready");
    pulseAccept(); // list 2 0 3 1
    headReady = '1;
    expectGrant(1'b1, 2, "R4 front after middle move");
    setStatus(2, 3'd3);
    expectGrant(1'b1, 0, "R1 trap pending skipped");
    setStatus(2, 3'd4);
    expectGrant(1'b1, 2, "R1 fetch trap allowed");
    setStatus(2, 3'd3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectGrant(1'b1, 0, "R4 no accept holds list");
    threadStatus = {4{3'd7}};
    expectGrant(1'b0, 0, "R1 reserved code");
  endtask

  task automatic testOldest();
    doReset();
    policyMode = 1'b1;
    threadStatus = '0; headReady = '1; robEmpty = '0;
    setSeqs(40, 10, 30, 20);
    expectGrant(1'b1, 1, "R5 smallest seq");
    robEmpty[1] = 1'b1;
    expectGrant(1'b1, 3, "R5 empty excluded");
    setStatus(3, 3'd1);
    expectGrant(1'b1, 3, "R1 idle allowed");
    setStatus(3, 3'd3);
    expectGrant(1'b1, 2, "R1 trap excluded oldest");
    threadStatus = '0; robEmpty = '0;
    setSeqs(5, 9, 5, 5);
    expectGrant(1'b1, 0, "R6 tie lowest index");
    headReady[0] = 1'b0;
    expectGrant(1'b1, 2, "R6 tie next index");
    robEmpty = '1; headReady = '1;
    expectGrant(1'b0, 0, "R7 oldest none non-empty");
  endtask

  task automatic testModeIgnore();
    doReset();
    policyMode = 1'b1;
    threadStatus = '0; headReady = '1; robEmpty = '0;
    setSeqs(40, 10, 30, 20);
    expectGrant(1'b1, 1, "R9 oldest before accepts");
    repeat (3) pulseAccept();
    policyMode = 1'b0;
    expectGrant(1'b1, 0, "R9 list untouched by oldest accepts");
    pulseAccept();
    expectGrant(1'b1, 1, "R9 rotation resumes");
    headReady = '0;
    expectGrant(1'b0, 0, "R7 rr nothing ready");
  endtask

  task automatic chkSingle(input logic v, input string req);
    #1;
    vecCount++;
    if (sValid !== v || sThread !== 1'b0) begin
      errCount++;
      $display("FAIL %s: got valid=%0b thread=%0d, expected valid=%0b thread=0",
               req, sValid, sThread, v);
    end
  endtask

  task automatic testSingle();
    doReset();
    policyMode = 1'b1;
    sStatus = 3'd0; sReady = 1'b0; sEmpty = 1'b1;
    chkSingle(1'b1, "R8 running bypass");
    sStatus = 3'd2;
    chkSingle(1'b0, "R8 squashing blocked");
    sStatus = 3'd4; policyMode = 1'b0;
    chkSingle(1'b1, "R8 fetch trap bypass");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish();
  end

  initial begin
    testReset();
    testRoundRobin();
    testOldest();
    testModeIgnore();
    testSingle();
    finish();
  end

endmodule